// File: doc/BRIEF.md
# I2C Bus Idle Watchdog with Stuck-Line Recovery

This block watches the two lines of an I2C bus and measures how long they have been quiet. Once the quiet time reaches a selectable limit, it looks at the data line. If the data line is high, the bus is reported as free. If the data line is held low, it assumes a target device has stalled mid-byte. It then pulls the clock line low and releases it, up to nine times, so that the stalled device can finish shifting and let go of the data line.

Any change on either line restarts the quiet-time count. A short limit (fast mode) or a long limit (slow mode) is picked by a select input, and a disable input switches the whole function off. That includes a recovery already in progress, which stops at once. The pulse high and low phase lengths come from a shared timing tick. After a recovery ends, the block reports the data-line level it saw last and goes back to watching the bus.

Top module: `i2c_idle_guard`

## Requirements
- R1: After reset, bus_free, recovering, scl_pull and sda_final are all 0.
- R2: The watchdog expires once the synchronized lines have shown no change for FAST_CYCLES clocks when fast_sel is 1, or for SLOW_CYCLES clocks when fast_sel is 0.
- R3: When the watchdog expires with synchronized SDA at 1, bus_free goes to 1 on the next clock. It stays at 1 until a line change is seen or wd_off is set.
- R4: When the watchdog expires with synchronized SDA at 0, recovering goes to 1 and scl_pull goes to 1 on the next clock. Each pulse is a low phase (scl_pull=1) and then a high phase (scl_pull=0). Each phase lasts PHASE_TICKS assertions of tick, and there are at most PULSES (9) pulses. Clock-line changes caused by the block itself do not restart the count.
- R5: A change on scl_in or sda_in, seen through a two-flop synchronizer, clears the idle count and clears bus_free.
- R6: At the end of each high phase, synchronized SDA is sampled. If it is 1, the recovery ends after that pulse.
- R7: When a recovery ends, sda_final takes the sampled SDA level, recovering returns to 0, and monitoring restarts from a zero idle count.
- R8: While wd_off is 1, bus_free stays 0 and no recovery starts. Setting wd_off during a recovery clears recovering and scl_pull on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sampled I2C clock line level |
| sda_in | input | 1 | Sampled I2C data line level |
| fast_sel | input | 1 | 1 selects the short timeout, 0 the long one |
| wd_off | input | 1 | 1 turns the watchdog off |
| tick | input | 1 | Shared pulse-timing tick, one clock wide |
| bus_free | output | 1 | Bus found idle with SDA high |
| recovering | output | 1 | Recovery pulse train in progress |
| scl_pull | output | 1 | Open-drain pull-down enable for the clock line |
| sda_final | output | 1 | SDA level sampled when the last recovery ended |

## Verification
The hardest case to reach is a stalled device that lets go of SDA partway through the pulse train. The release has to land inside one specific high phase, and the two-flop synchronizer delays what the block sees. To get there, the bench models the open-drain clock wire and counts the falling edges of scl_pull as they happen. It releases SDA right after the third pulse begins its high phase. The bench also aborts a recovery midway with wd_off. A behavioural model follows every case clock by clock.

// File: rtl/idle_guard_pkg.sv
package idle_guard_pkg;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int LINES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_in,
    output logic [LINES-1:0] sync_out,
    output logic             change_any
);

    typedef struct packed {
        logic [LINES-1:0] meta;
        logic [LINES-1:0] stab;
        logic [LINES-1:0] prev;
    } sync_t;

    sync_t s_d, s_q;
    logic [LINES-1:0] chg;

    always_comb begin
        s_d      = s_q;
        s_d.meta = raw_in;
        s_d.stab = s_q.meta;
        s_d.prev = s_q.stab;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{meta: '1, stab: '1, prev: '1};
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar g = 0; g < LINES; g++) begin : g_line
        assign chg[g] = s_q.stab[g] ^ s_q.prev[g];
    end

    assign sync_out   = s_q.stab;
    assign change_any = |chg;

endmodule

// File: rtl/recovery_seq.sv
module recovery_seq
    import idle_guard_pkg::*;
#(
    parameter int PULSES      = 9,
    parameter int PHASE_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    input  logic tick,
    input  logic sda_s,
    output logic busy,
    output logic pull,
    output logic fin
);

    localparam int TK_W = (PHASE_TICKS > 1) ? $clog2(PHASE_TICKS) : 1;
    localparam int P_W  = $clog2(PULSES + 1);

    typedef struct packed {
        logic            busy;
        logic            pull;
        phase_e          ph;
        logic [TK_W-1:0] tk;
        logic [P_W-1:0]  cnt;
        logic            fin;
    } seq_t;

    seq_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!r_q.busy) begin
            if (start) begin
                r_d.busy = 1'b1;
                r_d.pull = 1'b1;
                r_d.ph   = PH_LOW;
                r_d.tk   = '0;
                r_d.cnt  = '0;
            end
        end else if (abort) begin
            r_d.busy = 1'b0;
            r_d.pull = 1'b0;
            r_d.ph   = PH_LOW;
            r_d.tk   = '0;
        end else if (tick) begin
            if (r_q.tk == TK_W'(PHASE_TICKS - 1)) begin
                r_d.tk = '0;
                if (r_q.ph == PH_LOW) begin
                    r_d.ph   = PH_HIGH;
                    r_d.pull = 1'b0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (sda_s || (r_q.cnt == P_W'(PULSES - 1))) begin
                        r_d.busy = 1'b0;
                        r_d.fin  = sda_s;
                    end else begin
                        r_d.ph   = PH_LOW;
                        r_d.pull = 1'b1;
                    end
                end
            end else begin
                r_d.tk = r_q.tk + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy = r_q.busy;
    assign pull = r_q.pull;
    assign fin  = r_q.fin;

    AST_PULL_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.pull |-> r_q.busy); // R4
    AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= P_W'(PULSES)); // R4
    AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && r_q.busy) |=> (!r_q.busy && !r_q.pull)); // R8
    AST_HIGH_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.busy && r_q.ph == PH_HIGH) |-> !r_q.pull); // R4

endmodule

// File: rtl/i2c_idle_guard.sv
module i2c_idle_guard #(
    parameter int FAST_CYCLES = 1250,
    parameter int SLOW_CYCLES = 25_000_000,
    parameter int PULSES      = 9,
    parameter int PHASE_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic fast_sel,
    input  logic wd_off,
    input  logic tick,
    output logic bus_free,
    output logic recovering,
    output logic scl_pull,
    output logic sda_final
);

    localparam int MAX_LIM = (SLOW_CYCLES > FAST_CYCLES) ? SLOW_CYCLES : FAST_CYCLES;
    localparam int CNT_W   = $clog2(MAX_LIM + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             free;
    } mon_t;

    mon_t m_d, m_q;

    logic [1:0]       lines_s;
    logic             change_any;
    logic             sda_s;
    logic             seq_busy;
    logic             seq_start;
    logic [CNT_W-1:0] lim_m1;

    line_sync #(.LINES(2)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_in     ({sda_in, scl_in}),
        .sync_out   (lines_s),
        .change_any (change_any)
    );

    assign sda_s  = lines_s[1];
    assign lim_m1 = fast_sel ? CNT_W'(FAST_CYCLES - 1) : CNT_W'(SLOW_CYCLES - 1);

    always_comb begin
        m_d       = m_q;
        seq_start = 1'b0;
        if (wd_off || seq_busy || change_any) begin
            m_d.cnt  = '0;
            m_d.free = 1'b0;
        end else if (m_q.cnt >= lim_m1) begin
            if (!m_q.free) begin
                if (sda_s) begin
                    m_d.free = 1'b1;
                end else begin
                    seq_start = 1'b1;
                end
            end
        end else begin
            m_d.cnt = m_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    recovery_seq #(
        .PULSES      (PULSES),
        .PHASE_TICKS (PHASE_TICKS)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (seq_start),
        .abort (wd_off),
        .tick  (tick),
        .sda_s (sda_s),
        .busy  (seq_busy),
        .pull  (scl_pull),
        .fin   (sda_final)
    );

    assign bus_free   = m_q.free;
    assign recovering = seq_busy;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        m_q.cnt <= CNT_W'(MAX_LIM)); // R2
    AST_FREE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        m_q.free |-> !seq_busy); // R3
    AST_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        change_any |=> !bus_free); // R5
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        wd_off |=> (!bus_free && !recovering)); // R8
    AST_START_SDA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |-> !sda_s); // R4

endmodule

// File: tb/sim_i2c_idle_guard.sv
`timescale 1ns/1ps
module sim_i2c_idle_guard;

    localparam int FAST = 40;
    localparam int SLOW = 300;
    localparam int PT   = 2;
    localparam int NP   = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_scl = 1'b1;
    logic sda_drv = 1'b1;
    logic fast_sel = 1'b1;
    logic wd_off = 1'b0;
    logic tick = 1'b0;
    logic bus_free, recovering, scl_pull, sda_final;
    logic scl_wire;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    assign scl_wire = ext_scl & ~scl_pull;

    always #5 clk = ~clk;

    i2c_idle_guard #(
        .FAST_CYCLES (FAST),
        .SLOW_CYCLES (SLOW),
        .PULSES      (NP),
        .PHASE_TICKS (PT)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl_wire),
        .sda_in     (sda_drv),
        .fast_sel   (fast_sel),
        .wd_off     (wd_off),
        .tick       (tick),
        .bus_free   (bus_free),
        .recovering (recovering),
        .scl_pull   (scl_pull),
        .sda_final  (sda_final)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit h_scl[3];
    bit h_sda[3];
    int m_idle;
    bit m_free, m_rec, m_pull, m_fin, m_hi;
    int m_pul, m_tk;

    always @(posedge clk) begin
        bit e, s;
        int lim;
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin h_scl[i] = 1'b1; h_sda[i] = 1'b1; end
            m_idle = 0; m_free = 0; m_rec = 0; m_pull = 0; m_fin = 0; m_hi = 0;
            m_pul = 0; m_tk = 0;
        end else begin
            e   = (h_scl[1] != h_scl[2]) || (h_sda[1] != h_sda[2]);
            s   = h_sda[1];
            lim = fast_sel ? FAST : SLOW;
            if (!m_rec) begin
                if (wd_off || e) begin
                    m_idle = 0; m_free = 0;
                end else if (m_idle >= lim - 1) begin
                    if (!m_free) begin
                        if (s) m_free = 1;
                        else begin m_rec = 1; m_pul = 0; m_hi = 0; m_tk = 0; m_pull = 1; end
                    end
                end else begin
                    m_idle++;
                end
            end else begin
                m_idle = 0;
                if (wd_off) begin
                    m_rec = 0; m_pull = 0; m_hi = 0; m_tk = 0;
                end else if (tick) begin
                    if (m_tk == PT - 1) begin
                        m_tk = 0;
                        if (!m_hi) begin
                            m_hi = 1; m_pull = 0;
                        end else begin
                            m_pul++;
                            if (s || m_pul == NP) begin m_rec = 0; m_fin = s; end
                            else begin m_hi = 0; m_pull = 1; end
                        end
                    end else begin
                        m_tk++;
                    end
                end
            end
            h_scl[2] = h_scl[1]; h_scl[1] = h_scl[0]; h_scl[0] = scl_wire;
            h_sda[2] = h_sda[1]; h_sda[1] = h_sda[0]; h_sda[0] = sda_drv;
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk(bus_free   == m_free, "R3 bus_free vs model",   bus_free,   m_free);
            chk(recovering == m_rec,  "R4 recovering vs model", recovering, m_rec);
            chk(scl_pull   == m_pull, "R4 scl_pull vs model",   scl_pull,   m_pull);
            chk(sda_final  == m_fin,  "R7 sda_final vs model",  sda_final,  m_fin);
        end
        if (cyc > 100000) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int k = 0;
        forever begin
            @(negedge clk);
            k = (k + 1) % 3;
            tick = (k == 0);
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_rec();
        int g = 0;
        while (!recovering && g < 2000) begin @(negedge clk); g++; end
    endtask

    task automatic run_pulses(input int rel_after, output int falls);
        bit prev = 1'b0;
        falls = 0;
        while (recovering) begin
            @(negedge clk);
            if (prev && !scl_pull) begin
                falls++;
                if (rel_after > 0 && falls == rel_after) sda_drv = 1'b1;
            end
            prev = scl_pull;
        end
    endtask

    initial begin
        int f;
        wait_n(4);
        rst_n = 1'b1;
        wait_n(1);
        chk(bus_free == 0 && recovering == 0 && scl_pull == 0 && sda_final == 0,
            "R1 reset outputs", {bus_free, recovering, scl_pull, sda_final}, 0);

        wait_n(FAST + 10);
        chk(bus_free == 1, "R2 fast timeout gives bus_free", bus_free, 1);
        chk(bus_free == 1, "R3 bus declared free with SDA high", bus_free, 1);

        sda_drv = 1'b0; wait_n(1); sda_drv = 1'b1;
        wait_n(4);
        chk(bus_free == 0, "R5 line change clears bus_free", bus_free, 0);

        fast_sel = 1'b0;
        wait_n(200);
        chk(bus_free == 0, "R2 slow timeout not yet expired", bus_free, 0);
        wait_n(SLOW);
        chk(bus_free == 1, "R2 slow timeout expired", bus_free, 1);

        fast_sel = 1'b1;
        sda_drv = 1'b0;
        wait_rec();
        chk(recovering == 1, "R4 recovery starts with SDA low", recovering, 1);
        run_pulses(0, f);
        chk(f == NP, "R4 nine pulses on stuck SDA", f, NP);
        chk(sda_final == 0, "R7 final SDA low", sda_final, 0);
        sda_drv = 1'b1;
        wait_n(6);
        chk(recovering == 0, "R7 back to monitoring", recovering, 0);

        wait_n(FAST + 10);
        sda_drv = 1'b0;
        wait_rec();
        run_pulses(3, f);
        chk(f == 3, "R6 early stop after release", f, 3);
        chk(sda_final == 1, "R7 final SDA high", sda_final, 1);

        wait_n(FAST + 10);
        sda_drv = 1'b0;
        wait_rec();
        wait_n(5);
        wd_off = 1'b1;
        wait_n(1);
        chk(scl_pull == 0 && recovering == 0, "R8 off aborts recovery",
            {recovering, scl_pull}, 0);
        sda_drv = 1'b1;
        wait_n(SLOW + 20);
        chk(bus_free == 0, "R8 off blocks bus_free", bus_free, 0);
        chk(recovering == 0, "R8 off blocks recovery", recovering, 0);

        wd_off = 1'b0;
        wait_n(FAST + 10);
        chk(bus_free == 1, "R3 free after enabling", bus_free, 1);

        ext_scl = 1'b0; wait_n(1); ext_scl = 1'b1;
        wait_n(4);
        chk(bus_free == 0, "R5 SCL change clears bus_free", bus_free, 0);
        wait_n(10);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule